// File: doc/BRIEF.md
# Speech ROM Fetch Sequencer

This block reads speech data from a byte-wide external ROM of up to 1 Mbit (17-bit byte address) and hands the bytes to a downstream decoder. A host selects one of 256 messages by placing a message number on `msg_code` and pulsing the start strobe low while chip-select is low. The message number is latched on the strobe's rising edge. The block then reads that message's start address from a directory at the bottom of the ROM and streams data bytes from consecutive addresses. It keeps streaming until the downstream logic raises `stop`.

Every ROM access uses an 8-bit bus that serves two purposes. At the start of an access the block drives the upper eight address bits onto the bus. An external latch captures them on the falling edge of `ale`. The lower nine address bits sit on dedicated pins for the whole access. The block then stops driving the bus (`bus_oe` low), holds `aen_n` low while the address is valid, and pulses `drq_n` low. It samples the ROM byte on the last clock of that pulse. `dir_flag` marks the two directory accesses.

Fetched bytes leave on a valid/ready port. A byte is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte and valid stay unchanged and no new ROM access begins. The next access starts only after the held byte has been taken, so the ROM is never read ahead.

Top module: `speech_rom_fetch`

## Requirements
- R1: After reset `busy`, `out_valid`, `ale`, `bus_oe` and `dir_flag` are low, and `aen_n` and `drq_n` are high.
- R2: A rising edge of `st_n` seen while `cs_n` is low and the block is idle starts a message and raises `busy`. The same edge with `cs_n` high starts nothing and no ROM access occurs.
- R3: While `busy` is high a start strobe is ignored. The message number in use does not change.
- R4: For message m the first two accesses read byte addresses 2m (start address high byte) and 2m+1 (low byte). `dir_flag` is high during these two accesses and low during data accesses.
- R5: Data accesses begin at byte address {high byte, low byte, 0} and step by one. The bytes appear on `out_data` in address order.
- R6: In each access `ale` is high for 2 clocks while the upper address byte is driven (`bus_o[7:0]` = address bits 16..9, `rom_addr_lo` = bits 8..0). `bus_oe` stays high in the clock right after `ale` falls.
- R7: `aen_n` is low for 20 clocks, only after `ale` has fallen and never while `bus_oe` is high. `drq_n` is low for 8 clocks inside the `aen_n` window, and `bus_i` is sampled on the last clock of that pulse.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay stable and no new access (`ale` pulse) begins.
- R9: `stop` returns the block to idle on the next clock. `busy` and `out_valid` drop and all strobes go inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, gates the start strobe |
| st_n | input | 1 | Start strobe; message number latched on its rising edge |
| msg_code | input | 8 | Message number |
| stop | input | 1 | End of message from the downstream decoder |
| rom_addr_lo | output | 9 | Lower address bits 8..0 |
| bus_o | output | 8 | Shared bus output value (upper address bits 16..9) |
| bus_oe | output | 1 | Shared bus output enable |
| bus_i | input | 8 | Shared bus input (ROM data) |
| ale | output | 1 | Upper-address latch strobe, captured on its falling edge |
| aen_n | output | 1 | Address valid, active low |
| drq_n | output | 1 | Data strobe, active low |
| dir_flag | output | 1 | High during directory accesses |
| busy | output | 1 | High while a message is in progress |
| out_data | output | 8 | Fetched byte |
| out_valid | output | 1 | Fetched byte available |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench models the external latch on the falling edge of `ale` and rebuilds each full 17-bit address. It checks the directory addresses for several message numbers, including message 0 and message 255. A design that placed the directory at the wrong offset or read the bytes in the wrong order would fetch from the wrong start address and return wrong data. Strobe widths are measured on every access, so an off-by-one phase counter shows up as a wrong pulse length. The bench holds `out_ready` low for a long time to catch a design that overwrites the held byte or keeps reading the ROM. It also sends start strobes while chip-select is high and while a message is running, to catch a design that switches message or restarts.

// File: rtl/sptr_pkg.sv
package sptr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR_HI,
    S_DIR_LO,
    S_DATA,
    S_HOLD
  } seq_state_e;
endpackage

// File: rtl/sptr_start.sv
module sptr_start (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic st_n,
  input  logic enable,
  output logic start
);
  logic st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b1;
    else        st_q <= st_n;
  end

  // rising edge of the strobe, gated by chip select and idle state
  assign start = enable && !cs_n && st_n && !st_q;
endmodule

// File: rtl/sptr_cycle.sv
module sptr_cycle #(
  parameter int AW        = 17,
  parameter int LOW_W     = 9,
  parameter int CYC_CLKS  = 24,
  parameter int ALE_CLKS  = 2,
  parameter int STB_START = 8,
  parameter int STB_CLKS  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                kill,
  input  logic [AW-1:0]       addr,
  output logic [LOW_W-1:0]    addr_lo,
  output logic [AW-LOW_W-1:0] bus_o,
  output logic                bus_oe,
  output logic                ale,
  output logic                aen_n,
  output logic                drq_n,
  output logic                cap,
  output logic                done
);
  localparam int PH_W = $clog2(CYC_CLKS);

  logic            active;
  logic [PH_W-1:0] ph;
  logic [AW-1:0]   addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      addr_q <= '0;
    end else if (kill) begin
      active <= 1'b0;
      ph     <= '0;
    end else if (go && !active) begin
      active <= 1'b1;
      ph     <= '0;
      addr_q <= addr;
    end else if (active) begin
      if (ph == PH_W'(CYC_CLKS - 1)) begin
        active <= 1'b0;
        ph     <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign addr_lo = addr_q[LOW_W-1:0];
  assign bus_o   = addr_q[AW-1:LOW_W];
  assign ale     = active && (ph < PH_W'(ALE_CLKS));
  assign bus_oe  = active && (ph <= PH_W'(ALE_CLKS));
  assign aen_n   = !(active && (ph > PH_W'(ALE_CLKS)) && (ph < PH_W'(CYC_CLKS - 1)));
  assign drq_n   = !(active && (ph >= PH_W'(STB_START)) && (ph < PH_W'(STB_START + STB_CLKS)));
  assign cap     = active && (ph == PH_W'(STB_START + STB_CLKS - 1));
  assign done    = active && (ph == PH_W'(CYC_CLKS - 1));

  // R6: upper byte still on the bus when the latch strobe falls
  p_ale_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) && !$past(kill) |-> bus_oe);
  // R7: address-valid window never overlaps the driven bus
  p_aen_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !aen_n |-> !bus_oe && !ale);
  // R7: data strobe sits inside the address-valid window
  p_drq_in_aen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drq_n |-> !aen_n);
endmodule

// File: rtl/speech_rom_fetch.sv
module speech_rom_fetch #(
  parameter int AW        = 17,
  parameter int LOW_W     = 9,
  parameter int DW        = 8,
  parameter int CYC_CLKS  = 24,
  parameter int ALE_CLKS  = 2,
  parameter int STB_START = 8,
  parameter int STB_CLKS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             st_n,
  input  logic [DW-1:0]    msg_code,
  input  logic             stop,
  output logic [LOW_W-1:0] rom_addr_lo,
  output logic [DW-1:0]    bus_o,
  output logic             bus_oe,
  input  logic [DW-1:0]    bus_i,
  output logic             ale,
  output logic             aen_n,
  output logic             drq_n,
  output logic             dir_flag,
  output logic             busy,
  output logic [DW-1:0]    out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  import sptr_pkg::*;

  seq_state_e    state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] hi_q, lo_q;
  logic          go_q, start, cap, done;

  sptr_start u_start (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .st_n(st_n),
    .enable(state == S_IDLE), .start(start)
  );

  sptr_cycle #(
    .AW(AW), .LOW_W(LOW_W), .CYC_CLKS(CYC_CLKS), .ALE_CLKS(ALE_CLKS),
    .STB_START(STB_START), .STB_CLKS(STB_CLKS)
  ) u_cycle (
    .clk(clk), .rst_n(rst_n), .go(go_q), .kill(stop), .addr(addr_q),
    .addr_lo(rom_addr_lo), .bus_o(bus_o), .bus_oe(bus_oe), .ale(ale),
    .aen_n(aen_n), .drq_n(drq_n), .cap(cap), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      go_q      <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (stop) begin
        state     <= S_IDLE;
        out_valid <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            addr_q <= AW'({msg_code, 1'b0});
            state  <= S_DIR_HI;
            go_q   <= 1'b1;
          end
          S_DIR_HI: begin
            if (cap) hi_q <= bus_i;
            if (done) begin
              addr_q <= addr_q + 1'b1;
              state  <= S_DIR_LO;
              go_q   <= 1'b1;
            end
          end
          S_DIR_LO: begin
            if (cap) lo_q <= bus_i;
            if (done) begin
              addr_q <= AW'({hi_q, lo_q, 1'b0});
              state  <= S_DATA;
              go_q   <= 1'b1;
            end
          end
          S_DATA: begin
            if (cap) begin
              out_data  <= bus_i;
              out_valid <= 1'b1;
            end
            if (done) state <= S_HOLD;
          end
          S_HOLD: if (!out_valid || out_ready) begin
            addr_q <= addr_q + 1'b1;
            state  <= S_DATA;
            go_q   <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign dir_flag = (state == S_DIR_HI) || (state == S_DIR_LO);

  // R8: a held byte stays put until taken
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !stop |=> out_valid && $stable(out_data));
  // R8: no new access begins while a byte waits
  p_no_fetch_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> !out_valid);
  // R4: directory flag only inside a running message
  p_dir_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_flag |-> busy);
  // R9: stop empties the block on the next clock
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy && !out_valid);
endmodule

// File: tb/speech_rom_fetch_tb.sv
module speech_rom_fetch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, st_n = 1'b1, stop = 1'b0, out_ready = 1'b0;
  logic [7:0] msg_code = 8'h00;
  logic [8:0] rom_addr_lo;
  logic [7:0] bus_o, bus_i, out_data;
  logic       bus_oe, ale, aen_n, drq_n, dir_flag, busy, out_valid;

  int n_total = 0, n_fail = 0;
  logic [7:0]  ext_hi = 8'h00;
  logic [16:0] acc_addr [32];
  logic        acc_dir  [32];
  int acc_n = 0, ale_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  speech_rom_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .st_n(st_n), .msg_code(msg_code),
    .stop(stop), .rom_addr_lo(rom_addr_lo), .bus_o(bus_o), .bus_oe(bus_oe),
    .bus_i(bus_i), .ale(ale), .aen_n(aen_n), .drq_n(drq_n), .dir_flag(dir_flag),
    .busy(busy), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  function automatic logic [7:0] rom_byte(input logic [16:0] a);
    if (a < 17'd512) rom_byte = a[0] ? a[8:1] : {1'b1, a[7:1]};
    else             rom_byte = a[7:0] ^ {a[15:9], a[16]} ^ 8'h3C;
  endfunction

  function automatic logic [16:0] base_of(input logic [7:0] m);
    base_of = {1'b1, m[6:0], m, 1'b0};
  endfunction

  always @(negedge ale) ext_hi = bus_o;
  assign bus_i = bus_oe ? 8'h00 : rom_byte({ext_hi, rom_addr_lo});

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // access monitor: strobe widths and full address log
  logic p_ale = 0, p_drq = 1, p_aen = 1;
  int ale_run = 0, drq_run = 0, aen_run = 0;
  always @(negedge clk) begin
    if (ale) ale_run++;
    if (!drq_n) drq_run++;
    if (!aen_n) aen_run++;
    if (ale && !p_ale) ale_cnt++;
    if (!ale && p_ale) begin
      if (busy) begin
        chk(ale_run == 2, "R6 ale width", ale_run, 2);
        chk(bus_oe == 1'b1, "R6 bus held after ale fall", bus_oe, 1);
      end
      ale_run = 0;
    end
    if (!drq_n && p_drq) begin
      if (acc_n < 32) begin
        acc_addr[acc_n] = {ext_hi, rom_addr_lo};
        acc_dir[acc_n]  = dir_flag;
        acc_n++;
      end
    end
    if (drq_n && !p_drq) begin
      if (busy) chk(drq_run == 8, "R7 drq width", drq_run, 8);
      drq_run = 0;
    end
    if (aen_n && !p_aen) begin
      if (busy) chk(aen_run == 20, "R7 aen width", aen_run, 20);
      aen_run = 0;
    end
    p_ale = ale; p_drq = drq_n; p_aen = aen_n;
  end

  task automatic pulse_start(input logic [7:0] m, input logic cs);
    @(negedge clk); msg_code = m; cs_n = cs; st_n = 1'b0;
    @(negedge clk); st_n = 1'b1;
    @(negedge clk); msg_code = ~m; cs_n = 1'b1;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 400; i++) begin
      if (out_valid) return;
      @(negedge clk);
    end
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!busy && !out_valid, "R9 idle after stop", {busy, out_valid}, 0);
    chk(!ale && aen_n && drq_n && !bus_oe, "R9 strobes released",
        {ale, aen_n, drq_n, bus_oe}, 4'b0110);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !out_valid && !ale && !bus_oe && !dir_flag, "R1 low outputs",
        {busy, out_valid, ale, bus_oe, dir_flag}, 0);
    chk(aen_n && drq_n, "R1 high strobes", {aen_n, drq_n}, 2'b11);
  endtask

  task automatic t_stream(input logic [7:0] m, input int n);
    logic [16:0] b;
    b = base_of(m);
    out_ready = 1'b1; acc_n = 0;
    pulse_start(m, 1'b0);
    chk(busy, "R2 busy after start", busy, 1);
    for (int k = 0; k < n; k++) begin
      wait_valid();
      chk(out_data == rom_byte(b + 17'(k)), "R5 data byte", out_data, rom_byte(b + 17'(k)));
      @(negedge clk);
    end
    chk(acc_addr[0] == {8'h00, m, 1'b0}, "R4 dir high addr", acc_addr[0], {m, 1'b0});
    chk(acc_addr[1] == {8'h00, m, 1'b1}, "R4 dir low addr", acc_addr[1], {m, 1'b1});
    chk(acc_dir[0] && acc_dir[1], "R4 dir flag high", {acc_dir[0], acc_dir[1]}, 3);
    chk(!acc_dir[2], "R4 dir flag low in data", acc_dir[2], 0);
    for (int k = 0; k < n; k++)
      chk(acc_addr[2+k] == b + 17'(k), "R5 data addr", acc_addr[2+k], b + 17'(k));
    do_stop();
  endtask

  task automatic t_cs_gate();
    int c0;
    c0 = ale_cnt;
    pulse_start(8'h21, 1'b1);
    repeat (40) @(negedge clk);
    chk(!busy, "R2 cs high ignored", busy, 0);
    chk(ale_cnt == c0, "R2 no access", ale_cnt, c0);
  endtask

  task automatic t_busy_ignore(input logic [7:0] m);
    logic [16:0] b;
    b = base_of(m);
    out_ready = 1'b1;
    pulse_start(m, 1'b0);
    repeat (5) @(negedge clk);
    pulse_start(8'h99, 1'b0);
    for (int k = 0; k < 3; k++) begin
      wait_valid();
      chk(out_data == rom_byte(b + 17'(k)), "R3 start ignored while busy",
          out_data, rom_byte(b + 17'(k)));
      @(negedge clk);
    end
    do_stop();
  endtask

  task automatic t_backpressure(input logic [7:0] m);
    logic [16:0] b;
    logic [7:0]  d0;
    int c0;
    b = base_of(m);
    out_ready = 1'b0;
    pulse_start(m, 1'b0);
    wait_valid();
    d0 = out_data; c0 = ale_cnt;
    repeat (60) @(negedge clk);
    chk(out_valid && out_data == d0, "R8 byte held", out_data, d0);
    chk(ale_cnt == c0, "R8 no fetch while held", ale_cnt, c0);
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    wait_valid();
    chk(out_data == rom_byte(b + 17'd1), "R8 next byte after release",
        out_data, rom_byte(b + 17'd1));
    do_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream(8'h05, 4);
    t_stream(8'h00, 3);
    t_stream(8'hFF, 3);
    t_cs_gate();
    t_busy_ignore(8'h42);
    t_backpressure(8'h13);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule